// File: doc/BRIEF.md
# Programmable External Bus Bank Controller

This block turns single internal memory requests into chip-select and strobe sequences for a set of external memory banks. The request carries a byte address, a size (byte, half-word or word), a write flag and write data. The controller picks the bank from the upper address bits. It then runs one or more bus beats, each lengthened by that bank's programmed wait states. When the final beat is over, it returns a one-cycle ready pulse together with the assembled read data.

Each bank has its own settings, given as static configuration inputs: wait states, a data-float hold-off, the bus width (8 or 16 bits), the 16-bit byte-handling style, and an early-read enable. A 16-bit bank can serve one 16-bit device, whose lanes are qualified by byte selects under a common write strobe. It can also serve a pair of 8-bit devices, each with its own lane write strobe. Accesses wider than the bus are split into ascending beats. After an access, a bank's float count keeps any other bank off the bus until the count has drained.

Top module: `ebb_ctrl`

## Requirements
- R1: With the default geometry of eight 1-Mbyte banks, the bank index is address bits [22:20]; with the large geometry of four 16-Mbyte banks, it is bits [25:24]. During an access exactly one active-low chip select, the one for that index, is low, and all others are high.
- R2: Each beat holds its active-low read or write strobe for exactly W+1 cycles, where W is the bank's wait-state setting.
- R3: After the final beat on bank A, a request to a different bank B starts only once A's float count F has drained. A request presented in the ready cycle then sees max(1,F) further all-high chip-select cycles before B's chip select falls. A request to the same bank sees exactly 1.
- R4: On an 8-bit bank, byte, half-word and word accesses take 1, 2 and 4 beats at ascending byte addresses. Data travels on bus bits [7:0], and the common write strobe is used.
- R5: On a 16-bit bank, a word access takes two beats: first at the word address, carrying data bits [15:0], then at address+2, carrying bits [31:16]. Byte and half-word accesses take one beat.
- R6: In byte-select mode, a 16-bit bank drives the common write strobe and holds the active-low byte selects low during the whole access for the active lanes only. Lane 0 (select bit 0, bus bits [7:0]) is the even byte, and lane 1 is the odd byte.
- R7: In byte-write mode, a 16-bit write pulls low only the lane write strobes of the active lanes (bit 0 is the even byte). The common write strobe and the byte selects stay high. A read uses only the read strobe.
- R8: With a bank's early-read bit set, a read strobe falls in the same cycle as the chip select. With the bit clear, every read beat is preceded by one cycle with the chip select low and the read strobe high. Writes never have that extra cycle.
- R9: Ready is high for exactly one cycle, the one after the final strobe cycle. Read data is valid in that cycle, with byte k of the 32-bit data belonging to address offset k within the word.
- R10: After reset, all chip selects, strobes and byte selects are high, and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until ready |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, byte k at offset k |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, valid with ready |
| cfg_wait | input | NB*WS_W | Wait states per bank |
| cfg_float | input | NB*FL_W | Float hold-off cycles per bank |
| cfg_wide | input | NB | 1 selects a 16-bit bus for the bank |
| cfg_bytewr | input | NB | 1 selects byte-write mode, 0 byte-select |
| cfg_early | input | NB | Early-read enable per bank |
| ext_addr | output | ADDR_W | Byte address of the current beat |
| ext_ncs | output | NB | Active-low chip selects |
| ext_nrd | output | 1 | Active-low read strobe |
| ext_nwe | output | 1 | Active-low common write strobe |
| ext_nwe_lane | output | 2 | Active-low per-lane write strobes |
| ext_nbs | output | 2 | Active-low byte selects |
| ext_dout | output | 16 | Write data on the bus |
| ext_din | input | 16 | Read data from the bus |

## Verification
The expiry of a bank's float count and the arrival of a request for a different bank can land in the same cycle. This decides whether the new chip select falls one cycle early or is correctly held back. The bench provokes the case by issuing the next request in the very cycle that ready is seen, with float settings of 0, 1 and 5 and both same-bank and cross-bank targets. It then counts the all-high chip-select cycles before the new access and compares the count with max(1,F). The same chained timing also makes the ready pulse coincide with the next request, which must not be taken twice.

// File: rtl/ebb_pkg.sv
package ebb_pkg;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE} ebb_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // index of the final beat for a size on a given bus width
  function automatic logic [1:0] last_beat(input logic [1:0] size, input logic wide);
    if (wide) return (size >= 2'd2) ? 2'd1 : 2'd0;
    case (size)
      SZ_BYTE: return 2'd0;
      SZ_HALF: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  // byte offset of beat idx from the request address
  function automatic logic [1:0] beat_offset(input logic [1:0] idx, input logic wide);
    return wide ? {idx[0], 1'b0} : idx;
  endfunction

  // active byte lanes of a beat (bit 0 = even byte)
  function automatic logic [1:0] lane_mask(input logic [1:0] size, input logic wide,
                                           input logic a0);
    if (!wide) return 2'b01;
    if (size == SZ_BYTE) return a0 ? 2'b10 : 2'b01;
    return 2'b11;
  endfunction

endpackage

// File: rtl/ebb_bank_decode.sv
module ebb_bank_decode #(
  parameter int NB         = 8,
  parameter int SEL_W      = 3,
  parameter int BANK_SHIFT = 20,
  parameter int ADDR_W     = 23,
  parameter int WS_W       = 4,
  parameter int FL_W       = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NB*WS_W-1:0]   cfg_wait,
  input  logic [NB*FL_W-1:0]   cfg_float,
  input  logic [NB-1:0]        cfg_wide,
  input  logic [NB-1:0]        cfg_bytewr,
  input  logic [NB-1:0]        cfg_early,
  output logic [SEL_W-1:0]     bank,
  output logic [WS_W-1:0]      wait_v,
  output logic [FL_W-1:0]      float_v,
  output logic                 wide,
  output logic                 bwm,
  output logic                 early
);
  logic [WS_W-1:0] w_arr [NB];
  logic [FL_W-1:0] f_arr [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign w_arr[g] = cfg_wait[g*WS_W +: WS_W];
    assign f_arr[g] = cfg_float[g*FL_W +: FL_W];
  end

  assign bank    = addr[BANK_SHIFT +: SEL_W];
  assign wait_v  = w_arr[bank];
  assign float_v = f_arr[bank];
  assign wide    = cfg_wide[bank];
  assign bwm     = cfg_bytewr[bank];
  assign early   = cfg_early[bank];
endmodule

// File: rtl/ebb_float_guard.sv
module ebb_float_guard #(
  parameter int SEL_W = 3,
  parameter int FL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] load_bank,
  input  logic [FL_W-1:0]  load_val,
  input  logic [SEL_W-1:0] req_bank,
  input  logic             accept,
  output logic             stall
);
  logic [FL_W-1:0]  cnt;
  logic [SEL_W-1:0] owner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      owner <= '0;
    end else if (load) begin
      cnt   <= load_val;
      owner <= load_bank;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign stall = (cnt != '0) && (req_bank != owner);

  // R3: another bank never starts while the owner's float count is live
  assert_float_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (cnt == '0 || req_bank == owner));
endmodule

// File: rtl/ebb_lane_map.sv
module ebb_lane_map (
  input  logic        in_access,
  input  logic        strobe_on,
  input  logic        wr,
  input  logic        wide,
  input  logic        bwm,
  input  logic [1:0]  lanes,
  input  logic [1:0]  bbyte,
  input  logic [31:0] wdata,
  output logic        nrd,
  output logic        nwe,
  output logic [1:0]  nwe_lane,
  output logic [1:0]  nbs,
  output logic [15:0] dout
);
  logic       wr_act;
  logic [1:0] lo_k, hi_k;
  logic [7:0] lo_b, hi_b, nb_b;

  assign wr_act   = strobe_on && wr;
  assign nrd      = !(strobe_on && !wr);
  assign nwe      = !(wr_act && !(wide && bwm));
  assign nwe_lane = (wr_act && wide && bwm) ? ~lanes : 2'b11;
  assign nbs      = (in_access && wide && !bwm) ? ~lanes : 2'b11;

  assign lo_k = {bbyte[1], 1'b0};
  assign hi_k = {bbyte[1], 1'b1};
  assign lo_b = wdata[{lo_k, 3'b000} +: 8];
  assign hi_b = wdata[{hi_k, 3'b000} +: 8];
  assign nb_b = wdata[{bbyte, 3'b000} +: 8];
  assign dout = wide ? {hi_b, lo_b} : {8'h00, nb_b};
endmodule

// File: rtl/ebb_ctrl.sv
module ebb_ctrl
  import ebb_pkg::*;
#(
  parameter int LARGE_BANKS = 0,
  parameter int NB          = (LARGE_BANKS != 0) ? 4 : 8,
  parameter int BANK_SHIFT  = (LARGE_BANKS != 0) ? 24 : 20,
  parameter int SEL_W       = $clog2(NB),
  parameter int ADDR_W      = BANK_SHIFT + SEL_W,
  parameter int WS_W        = 4,
  parameter int FL_W        = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_write,
  input  logic [31:0]         req_wdata,
  output logic                req_ready,
  output logic [31:0]         req_rdata,
  input  logic [NB*WS_W-1:0]  cfg_wait,
  input  logic [NB*FL_W-1:0]  cfg_float,
  input  logic [NB-1:0]       cfg_wide,
  input  logic [NB-1:0]       cfg_bytewr,
  input  logic [NB-1:0]       cfg_early,
  output logic [ADDR_W-1:0]   ext_addr,
  output logic [NB-1:0]       ext_ncs,
  output logic                ext_nrd,
  output logic                ext_nwe,
  output logic [1:0]          ext_nwe_lane,
  output logic [1:0]          ext_nbs,
  output logic [15:0]         ext_dout,
  input  logic [15:0]         ext_din
);
  ebb_state_e       st;
  logic [SEL_W-1:0] bank_q, dec_bank;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]       size_q, bidx, last_q, off, bbyte, lanes;
  logic             wr_q, wide_q, bwm_q, early_q;
  logic [31:0]      wdata_q, rdata_q;
  logic [WS_W-1:0]  wait_q, wcnt, dec_wait;
  logic [FL_W-1:0]  float_q, dec_float;
  logic             dec_wide, dec_bwm, dec_early;
  logic             rdy_q, stall;

  // named internal events
  logic accept, beat_end, last_end;
  logic [3:0] cap_en;
  logic [7:0] cap_val [4];

  ebb_bank_decode #(.NB(NB), .SEL_W(SEL_W), .BANK_SHIFT(BANK_SHIFT), .ADDR_W(ADDR_W),
                    .WS_W(WS_W), .FL_W(FL_W)) u_dec (
    .addr(req_addr), .cfg_wait(cfg_wait), .cfg_float(cfg_float), .cfg_wide(cfg_wide),
    .cfg_bytewr(cfg_bytewr), .cfg_early(cfg_early), .bank(dec_bank), .wait_v(dec_wait),
    .float_v(dec_float), .wide(dec_wide), .bwm(dec_bwm), .early(dec_early));

  ebb_float_guard #(.SEL_W(SEL_W), .FL_W(FL_W)) u_float (
    .clk(clk), .rst_n(rst_n), .load(last_end), .load_bank(bank_q), .load_val(float_q),
    .req_bank(dec_bank), .accept(accept), .stall(stall));

  assign accept   = (st == S_IDLE) && req_valid && !rdy_q && !stall;
  assign beat_end = (st == S_STROBE) && (wcnt == '0);
  assign last_end = beat_end && (bidx == last_q);

  assign off   = beat_offset(bidx, wide_q);
  assign bbyte = addr_q[1:0] + off;
  assign lanes = lane_mask(size_q, wide_q, addr_q[0]);

  for (genvar g = 0; g < 4; g++) begin : g_cap
    localparam logic [1:0] GI = 2'(g);
    assign cap_en[g]  = wide_q ? ((GI[1] == bbyte[1]) && lanes[GI[0]]) : (GI == bbyte);
    assign cap_val[g] = (wide_q && GI[0]) ? ext_din[15:8] : ext_din[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bank_q  <= '0;
      addr_q  <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      wide_q  <= 1'b0;
      bwm_q   <= 1'b0;
      early_q <= 1'b0;
      wait_q  <= '0;
      float_q <= '0;
      wcnt    <= '0;
      bidx    <= '0;
      last_q  <= '0;
      rdata_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          bank_q  <= dec_bank;
          addr_q  <= req_addr;
          size_q  <= req_size;
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          wide_q  <= dec_wide;
          bwm_q   <= dec_bwm;
          early_q <= dec_early;
          wait_q  <= dec_wait;
          float_q <= dec_float;
          wcnt    <= dec_wait;
          bidx    <= '0;
          last_q  <= last_beat(req_size, dec_wide);
          rdata_q <= '0;
          st      <= (!req_write && !dec_early) ? S_SETUP : S_STROBE;
        end
        S_SETUP: st <= S_STROBE;
        S_STROBE: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
          end else begin
            if (!wr_q) begin
              for (int k = 0; k < 4; k++)
                if (cap_en[k]) rdata_q[8*k +: 8] <= cap_val[k];
            end
            if (bidx == last_q) begin
              st    <= S_IDLE;
              rdy_q <= 1'b1;
            end else begin
              bidx <= bidx + 1'b1;
              wcnt <= wait_q;
              st   <= (!wr_q && !early_q) ? S_SETUP : S_STROBE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ext_ncs = '1;
    if (st != S_IDLE) ext_ncs[bank_q] = 1'b0;
  end

  assign ext_addr  = addr_q + {{(ADDR_W-2){1'b0}}, off};
  assign req_ready = rdy_q;
  assign req_rdata = rdata_q;

  ebb_lane_map u_lanes (
    .in_access(st != S_IDLE), .strobe_on(st == S_STROBE), .wr(wr_q), .wide(wide_q),
    .bwm(bwm_q), .lanes(lanes), .bbyte(bbyte), .wdata(wdata_q), .nrd(ext_nrd),
    .nwe(ext_nwe), .nwe_lane(ext_nwe_lane), .nbs(ext_nbs), .dout(ext_dout));

  // checker counter: strobe cycles spent in the current beat
  logic [WS_W-1:0] chk_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_run <= '0;
    else if (st == S_STROBE) chk_run <= beat_end ? '0 : chk_run + 1'b1;
    else chk_run <= '0;
  end

  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_ncs));
  assert_wait_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_end |-> (chk_run == wait_q));
  assert_bs_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_nbs != 2'b11) |-> (ext_ncs != '1));
  assert_lane_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_nwe_lane != 2'b11) |-> (ext_nwe && ext_nbs == 2'b11 && ext_nrd));
  assert_setup_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETUP) |-> (!wr_q && !early_q && ext_nrd));
  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
endmodule

// File: tb/tb_ebb_ctrl.sv
module tb_ebb_ctrl;
  localparam int NB = 8;
  localparam int AW = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic req_ready;
  logic [31:0] req_rdata;
  logic [NB*4-1:0] cfg_wait = '0;
  logic [NB*3-1:0] cfg_float = '0;
  logic [NB-1:0] cfg_wide = '0, cfg_bytewr = '0, cfg_early = '0;
  logic [AW-1:0] ext_addr;
  logic [NB-1:0] ext_ncs;
  logic ext_nrd, ext_nwe;
  logic [1:0] ext_nwe_lane, ext_nbs;
  logic [15:0] ext_dout, ext_din;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ebb_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata), .cfg_wait(cfg_wait),
    .cfg_float(cfg_float), .cfg_wide(cfg_wide), .cfg_bytewr(cfg_bytewr),
    .cfg_early(cfg_early), .ext_addr(ext_addr), .ext_ncs(ext_ncs), .ext_nrd(ext_nrd),
    .ext_nwe(ext_nwe), .ext_nwe_lane(ext_nwe_lane), .ext_nbs(ext_nbs),
    .ext_dout(ext_dout), .ext_din(ext_din));

  function automatic logic [7:0] mb(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  // device model: pattern memory per byte address
  always_comb begin
    ext_din = 16'h0000;
    for (int i = 0; i < NB; i++)
      if (!ext_ncs[i])
        ext_din = cfg_wide[i] ? {mb({ext_addr[7:1], 1'b1}), mb({ext_addr[7:1], 1'b0})}
                              : {8'h00, mb(ext_addr[7:0])};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_bank(input int b, input int w, input int f, input logic wd,
                          input logic bw, input logic er);
    cfg_wait[b*4 +: 4]  = 4'(w);
    cfg_float[b*3 +: 3] = 3'(f);
    cfg_wide[b]   = wd;
    cfg_bytewr[b] = bw;
    cfg_early[b]  = er;
  endtask

  // trace results of one access
  int n_idle, n_acc, n_strobe, n_setup, n_beats, n_nwe, cs_seen;
  logic [AW-1:0] first_a, last_a;
  logic [1:0] nbs_mask, lane_seen;
  logic [15:0] first_do, last_do;
  logic [31:0] rd_res;

  task automatic run(input logic [AW-1:0] a, input logic [1:0] sz, input logic wr,
                     input logic [31:0] wd);
    logic started, prev_cs, strobe;
    logic [AW-1:0] prev_a;
    n_idle = 0; n_acc = 0; n_strobe = 0; n_setup = 0; n_beats = 0; n_nwe = 0;
    cs_seen = -1; nbs_mask = 2'b00; lane_seen = 2'b00; first_do = '0; last_do = '0;
    first_a = '0; last_a = '0;
    started = 1'b0; prev_cs = 1'b0; prev_a = '0;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (req_ready) break;
      if (ext_ncs == '1) begin
        if (!started) n_idle++;
        prev_cs = 1'b0;
      end else begin
        started = 1'b1;
        n_acc++;
        for (int i = 0; i < NB; i++) if (!ext_ncs[i]) cs_seen = i;
        if (!prev_cs || ext_addr != prev_a) begin
          n_beats++;
          if (n_beats == 1) first_a = ext_addr;
          last_a = ext_addr;
        end
        prev_cs = 1'b1; prev_a = ext_addr;
        strobe = !ext_nrd || !ext_nwe || (ext_nwe_lane != 2'b11);
        if (strobe) begin
          if (n_strobe == 0) first_do = ext_dout;
          last_do = ext_dout;
          n_strobe++;
        end else begin
          n_setup++;
        end
        if (!ext_nwe) n_nwe++;
        nbs_mask  = nbs_mask | ~ext_nbs;
        lane_seen = lane_seen | ~ext_nwe_lane;
      end
    end
    rd_res = req_rdata;
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 ncs", 32'(ext_ncs), 32'hFF);
    chk("R10 strobes", {28'h0, ext_nrd, ext_nwe, ext_nwe_lane == 2'b11, ext_nbs == 2'b11},
        32'hF);
    chk("R10 ready", 32'(req_ready), 32'h0);
  endtask

  task automatic t_narrow;
    run(23'h000004, 2'd2, 1'b1, 32'h44332211);
    chk("R4 word beats", 32'(n_beats), 32'd4);
    chk("R4 first addr", 32'(first_a), 32'h4);
    chk("R4 last addr", 32'(last_a), 32'h7);
    chk("R4 first data", 32'(first_do), 32'h0011);
    chk("R4 last data", 32'(last_do), 32'h0044);
    chk("R4 common nwe", 32'(n_nwe), 32'd4);
    chk("R1 bank0 cs", 32'(cs_seen), 32'd0);
    @(negedge clk);
    chk("R9 ready dropped", 32'(req_ready), 32'h0);
    run(23'h000008, 2'd2, 1'b0, 32'h0);
    chk("R4 read beats", 32'(n_beats), 32'd4);
    chk("R8 early no setup", 32'(n_setup), 32'd0);
    chk("R9 narrow rdata", rd_res, {mb(8'h0B), mb(8'h0A), mb(8'h09), mb(8'h08)});
    @(negedge clk);
    run(23'h500002, 2'd1, 1'b0, 32'h0);
    chk("R1 bank5 cs", 32'(cs_seen), 32'd5);
    chk("R4 half beats", 32'(n_beats), 32'd2);
    chk("R2 strobe W3", 32'(n_strobe), 32'd8);
    chk("R8 setup per beat", 32'(n_setup), 32'd2);
    chk("R9 half rdata", rd_res, {mb(8'h03), mb(8'h02), 16'h0});
    @(negedge clk);
  endtask

  task automatic t_wide_bs;
    run(23'h100008, 2'd2, 1'b1, 32'hDDCCBBAA);
    chk("R5 beats", 32'(n_beats), 32'd2);
    chk("R5 first addr", 32'(first_a), 32'h100008);
    chk("R5 second addr", 32'(last_a), 32'h10000A);
    chk("R5 low half first", 32'(first_do), 32'hBBAA);
    chk("R5 high half", 32'(last_do), 32'hDDCC);
    chk("R2 strobe W1", 32'(n_strobe), 32'd4);
    chk("R8 write no setup", 32'(n_setup), 32'd0);
    chk("R6 both selects", 32'(nbs_mask), 32'h3);
    chk("R6 no lane strobe", 32'(lane_seen), 32'h0);
    @(negedge clk);
    run(23'h100005, 2'd0, 1'b1, 32'h0000AB00);
    chk("R6 odd select", 32'(nbs_mask), 32'h2);
    chk("R6 odd data", 32'(first_do), 32'hAB00);
    chk("R6 common nwe", 32'(n_nwe), 32'd2);
    @(negedge clk);
    run(23'h100008, 2'd2, 1'b0, 32'h0);
    chk("R8 setup 2 beats", 32'(n_setup), 32'd2);
    chk("R5 access cycles", 32'(n_acc), 32'd6);
    chk("R9 wide rdata", rd_res, {mb(8'h0B), mb(8'h0A), mb(8'h09), mb(8'h08)});
    @(negedge clk);
    run(23'h300004, 2'd1, 1'b0, 32'h0);
    chk("R8 early wide", 32'(n_setup), 32'd0);
    chk("R2 strobe W2", 32'(n_strobe), 32'd3);
    @(negedge clk);
  endtask

  task automatic t_bytewr;
    run(23'h200002, 2'd0, 1'b1, 32'h00EE0000);
    chk("R7 lane0 only", 32'(lane_seen), 32'h1);
    chk("R7 no common nwe", 32'(n_nwe), 32'd0);
    chk("R7 no selects", 32'(nbs_mask), 32'h0);
    @(negedge clk);
    run(23'h200002, 2'd1, 1'b1, 32'h12340000);
    chk("R7 both lanes", 32'(lane_seen), 32'h3);
    @(negedge clk);
    run(23'h200002, 2'd1, 1'b0, 32'h0);
    chk("R7 read no lanes", 32'(lane_seen), 32'h0);
    chk("R9 bwm rdata", rd_res, {mb(8'h03), mb(8'h02), 16'h0});
    @(negedge clk);
    run(23'h7FFFF0, 2'd0, 1'b1, 32'h5A);
    chk("R1 bank7 cs", 32'(cs_seen), 32'd7);
    @(negedge clk);
  endtask

  // chained requests: the next request is presented in the ready cycle
  task automatic t_float;
    run(23'h100000, 2'd0, 1'b0, 32'h0);
    run(23'h200000, 2'd0, 1'b0, 32'h0);
    chk("R3 hold F5", 32'(n_idle), 32'd5);
    run(23'h100000, 2'd0, 1'b0, 32'h0);
    chk("R3 F0 other bank", 32'(n_idle), 32'd1);
    run(23'h100002, 2'd0, 1'b0, 32'h0);
    chk("R3 same bank", 32'(n_idle), 32'd1);
    run(23'h300000, 2'd0, 1'b0, 32'h0);
    chk("R3 hold after same", 32'(n_idle), 32'd5);
    run(23'h000000, 2'd0, 1'b0, 32'h0);
    chk("R3 F1 boundary", 32'(n_idle), 32'd1);
    @(negedge clk);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) set_bank(b, 0, 0, 1'b0, 1'b0, 1'b1);
    set_bank(1, 1, 5, 1'b1, 1'b0, 1'b0);
    set_bank(2, 0, 0, 1'b1, 1'b1, 1'b1);
    set_bank(3, 2, 1, 1'b1, 1'b0, 1'b1);
    set_bank(5, 3, 0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_narrow();
    t_wide_bs();
    t_bytewr();
    t_float();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule